// File: doc/BRIEF.md
# Redirection-Table Interrupt Message Router

This block turns wired interrupt requests into message-signalled writes. Each of its interrupt slots is governed by a 64-bit redirection entry, held by a separate register front end, that gives the vector, the delivery mode, the destination mode, the trigger mode, a mask and a 16-bit destination index. Requests are captured in a per-slot request register. A fixed-priority picker chooses the lowest-numbered eligible slot and formats one 32-bit address/data pair, which it presents on a valid/ready output.

Level-triggered slots take part in a remote-IRR handshake. Once a level slot has been delivered, its remote-IRR bit is set and the slot is not delivered again until an end-of-interrupt notice arrives whose vector matches the entry. Edge-triggered slots are delivered once for each unmasked rising edge. An edge that arrives while the slot is masked is lost. The remote-IRR bits are held inside this block and are exported so that the register front end can present them as part of the entry.

Top module: `irq_msg_router`

## Requirements
- R1: A synchronous active-high reset clears every request bit and every remote-IRR bit and drops `msg_valid`. A reset asserted mid-run takes effect at the next clock edge.
- R2: Input `pin_in[0]` drives slot 2, and slot 0 never requests. Inputs numbered `NUM_PINS` (24) and above have no effect.
- R3: Entry bit 15 set means level trigger. For a level slot, the request bit follows the input. While remote-IRR is clear, an asserted unmasked level slot produces one message and sets remote-IRR. While remote-IRR is set, no further message is sent.
- R4: Entry bit 15 clear means edge trigger, and entry bit 16 set means masked. An unmasked rising edge yields exactly one message, even if the input stays high. A rising edge seen while the slot is masked is discarded, and unmasking later sends nothing.
- R5: An entry configured for edge trigger has its remote-IRR bit (`rirr_o`) cleared by the next clock edge.
- R6: An end-of-interrupt with vector V clears remote-IRR on every slot whose remote-IRR is set and whose entry vector (bits 7:0) equals V. Such a slot is delivered again if it is unmasked and its request is still present. A non-matching vector changes nothing.
- R7: The message address is 0xFEE00000 with the destination index (entry bits 63:48) in address bits 19:4 and the destination-mode bit (entry bit 11) in address bit 2.
- R8: The message data carries the vector in bits 7:0, the delivery mode (entry bits 10:8) in bits 10:8 and the trigger mode in bit 15. All other data bits are zero.
- R9: When several slots are eligible, the lowest-numbered slot is sent first. While `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` hold steady.
- R10: A masked level slot with its input asserted is not delivered. Once it is unmasked, it is delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | IN_PINS (32) | Raw interrupt request inputs |
| route_tbl | input | NUM_PINS*64 | Redirection entries, slot i at bits [64*i +: 64] |
| eoi_valid | input | 1 | End-of-interrupt notice strobe |
| eoi_vec | input | 8 | Vector carried by the end-of-interrupt notice |
| msg_valid | output | 1 | Message pending on the output |
| msg_ready | input | 1 | Consumer accepts the message this cycle |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |
| rirr_o | output | NUM_PINS | Remote-IRR state per slot |

## Verification
The situation hardest to reach from the ports is an end-of-interrupt that arrives while a level slot is still asserted. In that case the slot must be delivered a second time and its remote-IRR must be set again in the same step. To get there, the bench raises a level input, waits for the first delivery and for several idle cycles that prove coalescing, sends a non-matching vector, and then sends the matching one. A second difficult case is a stalled output with two edges pending at once. The bench holds `msg_ready` low, pulses both inputs in the same cycle, checks that the held message is stable, and then releases the output to observe the delivery order.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
   localparam int ENTRY_W    = 64;
   localparam int VEC_W      = 8;
   localparam int DLV_W      = 3;
   localparam int DEST_W     = 16;
   localparam int MSG_W      = 32;

   // Field positions decoded from the register front end's entries
   localparam int F_VEC      = 0;
   localparam int F_DLV      = 8;
   localparam int F_DMODE    = 11;
   localparam int F_LEVEL    = 15;
   localparam int F_MASK     = 16;
   localparam int F_DEST     = 48;

   // Message data layout
   localparam int D_DLV      = 8;
   localparam int D_TRIG     = 15;

   typedef struct packed {
      logic [DEST_W-1:0] dest;
      logic              mask;
      logic              level;
      logic              dmode;
      logic [DLV_W-1:0]  dlv;
      logic [VEC_W-1:0]  vec;
   } route_t;

   function automatic route_t unpack_route(input logic [ENTRY_W-1:0] raw);
      route_t r;
      r.vec   = raw[F_VEC +: VEC_W];
      r.dlv   = raw[F_DLV +: DLV_W];
      r.dmode = raw[F_DMODE];
      r.level = raw[F_LEVEL];
      r.mask  = raw[F_MASK];
      r.dest  = raw[F_DEST +: DEST_W];
      return r;
   endfunction
endpackage

// File: rtl/irq_pin_map.sv
module irq_pin_map #(
   parameter int IN_PINS  = 32,
   parameter int NUM_PINS = 24,
   parameter bit REDIRECT = 1'b1
) (
   input  logic [IN_PINS-1:0]  pin_in,
   output logic [NUM_PINS-1:0] slot_req
);
   generate
      if (IN_PINS < NUM_PINS) begin : g_bad_width
         $error("irq_pin_map: IN_PINS must be at least NUM_PINS");
      end
      if (REDIRECT && NUM_PINS < 3) begin : g_bad_redirect
         $error("irq_pin_map: redirect needs at least three slots");
      end

      for (genvar g = 0; g < NUM_PINS; g++) begin : g_slot
         if (REDIRECT && g == 0) begin : g_dead
            assign slot_req[g] = 1'b0;
         end else if (REDIRECT && g == 2) begin : g_merge
            assign slot_req[g] = pin_in[0] | pin_in[2];
         end else begin : g_plain
            assign slot_req[g] = pin_in[g];
         end
      end

      if (IN_PINS > NUM_PINS) begin : g_drop
         logic unused_high;
         assign unused_high = ^pin_in[IN_PINS-1:NUM_PINS];
      end
   endgenerate
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
   parameter int NUM_PINS = 24
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [NUM_PINS-1:0] slot_req,
   input  logic [NUM_PINS-1:0] is_level,
   input  logic [NUM_PINS-1:0] is_masked,
   input  logic [NUM_PINS-1:0] served,
   output logic [NUM_PINS-1:0] irr
);
   logic [NUM_PINS-1:0] prev_q, irr_q, irr_d, rise;

   assign rise = slot_req & ~prev_q;

   always_comb begin
      for (int i = 0; i < NUM_PINS; i++) begin
         if (is_level[i])
            irr_d[i] = slot_req[i];
         else
            irr_d[i] = (irr_q[i] & ~served[i]) | (rise[i] & ~is_masked[i]);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q <= '0;
         irr_q  <= '0;
      end else begin
         prev_q <= slot_req;
         irr_q  <= irr_d;
      end
   end

   assign irr = irr_q;

   generate
      for (genvar g = 0; g < NUM_PINS; g++) begin : g_chk
         p_masked_edge_dropped_r4: assert property (@(posedge clk) disable iff (rst)
            (!is_level[g] && is_masked[g] && !irr_q[g]) |=> !irr_q[g]);
      end
   endgenerate
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
   parameter int NUM_PINS = 24,
   localparam int IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
   input  logic [NUM_PINS-1:0] req,
   output logic [NUM_PINS-1:0] grant,
   output logic [IDX_W-1:0]    idx,
   output logic                any
);
   always_comb begin
      grant = '0;
      idx   = '0;
      for (int i = NUM_PINS - 1; i >= 0; i--) begin
         if (req[i]) begin
            grant = '0;
            grant[i] = 1'b1;
            idx = IDX_W'(i);
         end
      end
   end

   assign any = |req;
endmodule

// File: rtl/irq_msg_fmt.sv
module irq_msg_fmt
   import irq_route_pkg::*;
#(
   parameter logic [MSG_W-1:0] MSG_BASE  = 32'hFEE0_0000,
   parameter int               DEST_LSB  = 4,
   parameter int               DMODE_BIT = 2
) (
   input  route_t             route,
   output logic [MSG_W-1:0]   addr,
   output logic [MSG_W-1:0]   data
);
   generate
      if (DEST_LSB + DEST_W > 20) begin : g_bad_dest
         $error("irq_msg_fmt: destination field overlaps fixed base");
      end
      if (DMODE_BIT >= DEST_LSB) begin : g_bad_dmode
         $error("irq_msg_fmt: destination mode bit overlaps destination");
      end
   endgenerate

   always_comb begin
      addr = MSG_BASE
           | (MSG_W'(route.dest) << DEST_LSB)
           | (MSG_W'(route.dmode) << DMODE_BIT);
      data = '0;
      data[VEC_W-1:0]       = route.vec;
      data[D_DLV +: DLV_W]  = route.dlv;
      data[D_TRIG]          = route.level;
   end
endmodule

// File: rtl/irq_msg_router.sv
module irq_msg_router
   import irq_route_pkg::*;
#(
   parameter int               IN_PINS   = 32,
   parameter int               NUM_PINS  = 24,
   parameter bit               REDIRECT  = 1'b1,
   parameter logic [31:0]      MSG_BASE  = 32'hFEE0_0000,
   parameter int               DEST_LSB  = 4,
   parameter int               DMODE_BIT = 2
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic [IN_PINS-1:0]           pin_in,
   input  logic [NUM_PINS*ENTRY_W-1:0]  route_tbl,
   input  logic                         eoi_valid,
   input  logic [VEC_W-1:0]             eoi_vec,
   output logic                         msg_valid,
   input  logic                         msg_ready,
   output logic [MSG_W-1:0]             msg_addr,
   output logic [MSG_W-1:0]             msg_data,
   output logic [NUM_PINS-1:0]          rirr_o
);
   localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

   route_t              routes [NUM_PINS];
   logic [NUM_PINS-1:0] lvl, msk, slot_req, irr, eligible, grant, served;
   logic [NUM_PINS-1:0] rirr_q, rirr_d, eoi_hit;
   logic [IDX_W-1:0]    pick_idx;
   logic                pick_any, take, fire;
   logic [MSG_W-1:0]    fmt_addr, fmt_data;
   logic                valid_q;
   logic [MSG_W-1:0]    addr_q, data_q;

   generate
      for (genvar g = 0; g < NUM_PINS; g++) begin : g_dec
         assign routes[g] = unpack_route(route_tbl[g*ENTRY_W +: ENTRY_W]);
         assign lvl[g]    = routes[g].level;
         assign msk[g]    = routes[g].mask;
         assign eoi_hit[g] = eoi_valid && rirr_q[g] && (routes[g].vec == eoi_vec);
      end
   endgenerate

   irq_pin_map #(.IN_PINS(IN_PINS), .NUM_PINS(NUM_PINS), .REDIRECT(REDIRECT)) u_map (
      .pin_in   (pin_in),
      .slot_req (slot_req)
   );

   irq_req_latch #(.NUM_PINS(NUM_PINS)) u_latch (
      .clk       (clk),
      .rst       (rst),
      .slot_req  (slot_req),
      .is_level  (lvl),
      .is_masked (msk),
      .served    (served),
      .irr       (irr)
   );

   // Level slots awaiting an end-of-interrupt are not eligible (coalescing)
   assign eligible = irr & ~msk & ~(lvl & rirr_q);

   irq_pick #(.NUM_PINS(NUM_PINS)) u_pick (
      .req   (eligible),
      .grant (grant),
      .idx   (pick_idx),
      .any   (pick_any)
   );

   assign take   = !valid_q || msg_ready;
   assign fire   = take && pick_any;
   assign served = fire ? grant : '0;

   irq_msg_fmt #(.MSG_BASE(MSG_BASE), .DEST_LSB(DEST_LSB), .DMODE_BIT(DMODE_BIT)) u_fmt (
      .route (routes[pick_idx]),
      .addr  (fmt_addr),
      .data  (fmt_data)
   );

   // Delivery sets remote-IRR after any clear from an end-of-interrupt
   assign rirr_d = lvl & ((rirr_q & ~eoi_hit) | served);

   always_ff @(posedge clk) begin
      if (rst) begin
         rirr_q  <= '0;
         valid_q <= 1'b0;
         addr_q  <= '0;
         data_q  <= '0;
      end else begin
         rirr_q <= rirr_d;
         if (fire) begin
            valid_q <= 1'b1;
            addr_q  <= fmt_addr;
            data_q  <= fmt_data;
         end else if (msg_ready) begin
            valid_q <= 1'b0;
         end
      end
   end

   assign msg_valid = valid_q;
   assign msg_addr  = addr_q;
   assign msg_data  = data_q;
   assign rirr_o    = rirr_q;

   p_reset_idle_r1: assert property (@(posedge clk) rst |=> !msg_valid && rirr_o == '0);

   p_hold_stalled_r9: assert property (@(posedge clk) disable iff (rst)
      (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

   p_addr_base_r7: assert property (@(posedge clk) disable iff (rst)
      msg_valid |-> (msg_addr[31:20] == MSG_BASE[31:20] && msg_addr[1:0] == 2'b00));

   p_data_clean_r8: assert property (@(posedge clk) disable iff (rst)
      msg_valid |-> (msg_data[31:16] == 16'h0 && msg_data[14:11] == 4'h0));

   generate
      for (genvar g = 0; g < NUM_PINS; g++) begin : g_chk
         p_edge_no_rirr_r5: assert property (@(posedge clk) disable iff (rst)
            !lvl[g] |=> !rirr_q[g]);
         p_no_repeat_level_r3: assert property (@(posedge clk) disable iff (rst)
            (served[g] && lvl[g]) |-> !rirr_q[g]);
         p_eoi_clears_r6: assert property (@(posedge clk) disable iff (rst)
            (eoi_hit[g] && !served[g]) |=> !rirr_q[g]);
      end
   endgenerate
endmodule

// File: tb/tb_irq_msg_router.sv
`timescale 1ns/1ps
module tb_irq_msg_router;
   localparam int IN_PINS  = 32;
   localparam int NUM_PINS = 24;

   logic                      clk = 1'b0;
   logic                      rst;
   logic [IN_PINS-1:0]        pin_in;
   logic [NUM_PINS*64-1:0]    route_tbl;
   logic                      eoi_valid;
   logic [7:0]                eoi_vec;
   logic                      msg_valid, msg_ready;
   logic [31:0]               msg_addr, msg_data;
   logic [NUM_PINS-1:0]       rirr_o;
   logic [63:0]               tbl [NUM_PINS];

   int checks = 0;
   int errors = 0;
   int n_msg  = 0;
   logic [31:0] log_addr [64];
   logic [31:0] log_data [64];

   always #2.5 clk = ~clk;

   for (genvar g = 0; g < NUM_PINS; g++) begin : g_flat
      assign route_tbl[g*64 +: 64] = tbl[g];
   end

   irq_msg_router dut (
      .clk(clk), .rst(rst), .pin_in(pin_in), .route_tbl(route_tbl),
      .eoi_valid(eoi_valid), .eoi_vec(eoi_vec), .msg_valid(msg_valid),
      .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data),
      .rirr_o(rirr_o)
   );

   always @(posedge clk) begin
      if (!rst && msg_valid && msg_ready && n_msg < 64) begin
         log_addr[n_msg] <= msg_addr;
         log_data[n_msg] <= msg_data;
         n_msg <= n_msg + 1;
      end
   end

   typedef struct packed {
      logic [7:0]  pin;
      logic [7:0]  vec;
      logic [2:0]  dlv;
      logic        dmode;
      logic [15:0] dest;
      logic [31:0] exp_addr;
      logic [31:0] exp_data;
   } case_t;

   localparam case_t CASES [4] = '{
      '{8'd5,  8'h31, 3'd0, 1'b0, 16'h0001, 32'hFEE0_0010, 32'h0000_0031},
      '{8'd9,  8'hA7, 3'd1, 1'b1, 16'h00FF, 32'hFEE0_0FF4, 32'h0000_01A7},
      '{8'd23, 8'h40, 3'd4, 1'b0, 16'hABCD, 32'hFEEA_BCD0, 32'h0000_0440},
      '{8'd1,  8'hFF, 3'd7, 1'b1, 16'hFFFF, 32'hFEEF_FFF4, 32'h0000_07FF}
   };

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic set_entry(input int idx, input logic [7:0] vec, input logic [2:0] dlv,
                            input logic dmode, input logic level, input logic mask,
                            input logic [15:0] dest);
      logic [63:0] e;
      e = '0;
      e[7:0]   = vec;
      e[10:8]  = dlv;
      e[11]    = dmode;
      e[15]    = level;
      e[16]    = mask;
      e[63:48] = dest;
      tbl[idx] = e;
   endtask

   task automatic pulse(input int p);
      pin_in[p] = 1'b1;
      tick(1);
      pin_in[p] = 1'b0;
   endtask

   task automatic send_eoi(input logic [7:0] v);
      eoi_vec = v;
      eoi_valid = 1'b1;
      tick(1);
      eoi_valid = 1'b0;
   endtask

   initial begin
      #(5.0 * 100000);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int base;
      rst = 1'b1; pin_in = '0; msg_ready = 1'b1; eoi_valid = 1'b0; eoi_vec = '0;
      for (int i = 0; i < NUM_PINS; i++) set_entry(i, 8'h00, 3'd0, 1'b0, 1'b0, 1'b1, 16'h0);
      tick(3);
      rst = 1'b0;
      tick(1);

      // R1: idle after reset
      chk("R1 valid", 32'(msg_valid), 32'h0);
      chk("R1 rirr", 32'(rirr_o), 32'h0);

      // R7/R8/R4: vector table of message formats via edge slots
      for (int k = 0; k < 4; k++) begin
         set_entry(CASES[k].pin, CASES[k].vec, CASES[k].dlv, CASES[k].dmode, 1'b0, 1'b0, CASES[k].dest);
         base = n_msg;
         pulse(CASES[k].pin);
         tick(4);
         chk("R4 one msg", 32'(n_msg - base), 32'd1);
         chk("R7 addr", log_addr[base], CASES[k].exp_addr);
         chk("R8 data", log_data[base], CASES[k].exp_data);
         set_entry(CASES[k].pin, 8'h00, 3'd0, 1'b0, 1'b0, 1'b1, 16'h0);
      end

      // R3: level delivery and coalescing
      set_entry(4, 8'h55, 3'd0, 1'b0, 1'b1, 1'b0, 16'h0003);
      base = n_msg;
      pin_in[4] = 1'b1;
      tick(6);
      chk("R3 first msg", 32'(n_msg - base), 32'd1);
      chk("R3 data", log_data[base], 32'h0000_8055);
      chk("R7 level addr", log_addr[base], 32'hFEE0_0030);
      chk("R3 rirr set", 32'(rirr_o[4]), 32'd1);
      tick(6);
      chk("R3 coalesced", 32'(n_msg - base), 32'd1);

      // R6: non-matching then matching end-of-interrupt
      send_eoi(8'h56);
      tick(3);
      chk("R6 nonmatch rirr", 32'(rirr_o[4]), 32'd1);
      chk("R6 nonmatch count", 32'(n_msg - base), 32'd1);
      send_eoi(8'h55);
      tick(4);
      chk("R6 redeliver", 32'(n_msg - base), 32'd2);
      chk("R6 rirr reset", 32'(rirr_o[4]), 32'd1);
      pin_in[4] = 1'b0;
      tick(2);
      send_eoi(8'h55);
      tick(4);
      chk("R6 cleared", 32'(rirr_o[4]), 32'd0);
      chk("R3 dropped request", 32'(n_msg - base), 32'd2);

      // R5: switching to edge clears remote-IRR
      pin_in[4] = 1'b1;
      tick(5);
      chk("R5 precondition", 32'(rirr_o[4]), 32'd1);
      set_entry(4, 8'h55, 3'd0, 1'b0, 1'b0, 1'b1, 16'h0003);
      tick(2);
      chk("R5 rirr cleared", 32'(rirr_o[4]), 32'd0);
      pin_in[4] = 1'b0;
      tick(2);

      // R4: masked edge discarded, held edge delivers once
      set_entry(7, 8'h77, 3'd0, 1'b0, 1'b0, 1'b1, 16'h0);
      base = n_msg;
      pulse(7);
      tick(3);
      set_entry(7, 8'h77, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0);
      tick(6);
      chk("R4 masked edge", 32'(n_msg - base), 32'd0);
      set_entry(8, 8'h88, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0);
      pin_in[8] = 1'b1;
      tick(10);
      chk("R4 held edge once", 32'(n_msg - base), 32'd1);
      pin_in[8] = 1'b0;
      set_entry(7, 8'h00, 3'd0, 1'b0, 1'b0, 1'b1, 16'h0);
      set_entry(8, 8'h00, 3'd0, 1'b0, 1'b0, 1'b1, 16'h0);
      tick(2);

      // R10: masked level held back until unmasked
      set_entry(12, 8'h12, 3'd0, 1'b0, 1'b1, 1'b1, 16'h0);
      base = n_msg;
      pin_in[12] = 1'b1;
      tick(6);
      chk("R10 masked", 32'(n_msg - base), 32'd0);
      set_entry(12, 8'h12, 3'd0, 1'b0, 1'b1, 1'b0, 16'h0);
      tick(5);
      chk("R10 unmasked", 32'(n_msg - base), 32'd1);
      chk("R10 data", log_data[base], 32'h0000_8012);
      pin_in[12] = 1'b0;
      tick(2);
      send_eoi(8'h12);
      tick(2);

      // R2: pin 0 redirected to slot 2, high pins ignored
      set_entry(0, 8'h10, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0);
      set_entry(2, 8'h22, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0);
      base = n_msg;
      pulse(0);
      tick(5);
      chk("R2 redirect count", 32'(n_msg - base), 32'd1);
      chk("R2 redirect vec", log_data[base], 32'h0000_0022);
      base = n_msg;
      pulse(24);
      pulse(31);
      tick(5);
      chk("R2 high pins", 32'(n_msg - base), 32'd0);
      set_entry(0, 8'h00, 3'd0, 1'b0, 1'b0, 1'b1, 16'h0);
      set_entry(2, 8'h00, 3'd0, 1'b0, 1'b0, 1'b1, 16'h0);

      // R9: stall hold and lowest-first order
      set_entry(3, 8'h33, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0);
      set_entry(6, 8'h66, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0);
      msg_ready = 1'b0;
      base = n_msg;
      pin_in[3] = 1'b1; pin_in[6] = 1'b1;
      tick(1);
      pin_in[3] = 1'b0; pin_in[6] = 1'b0;
      tick(3);
      chk("R9 valid stalled", 32'(msg_valid), 32'd1);
      chk("R9 first lowest", msg_data, 32'h0000_0033);
      tick(5);
      chk("R9 hold data", msg_data, 32'h0000_0033);
      chk("R9 hold valid", 32'(msg_valid), 32'd1);
      msg_ready = 1'b1;
      tick(4);
      chk("R9 count", 32'(n_msg - base), 32'd2);
      chk("R9 order 1", log_data[base], 32'h0000_0033);
      chk("R9 order 2", log_data[base+1], 32'h0000_0066);

      // R1: reset mid-run clears remote-IRR and output
      set_entry(12, 8'h12, 3'd0, 1'b0, 1'b1, 1'b0, 16'h0);
      pin_in[12] = 1'b1;
      tick(5);
      chk("R1 precondition", 32'(rirr_o[12]), 32'd1);
      rst = 1'b1;
      tick(1);
      chk("R1 rirr after reset", 32'(rirr_o), 32'h0);
      chk("R1 valid after reset", 32'(msg_valid), 32'h0);
      pin_in[12] = 1'b0;
      tick(1);
      rst = 1'b0;
      tick(2);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule